// File: doc/BRIEF.md
# Byte-Stream Boot Loader

This block sits at the front of an instruction engine and brings it up from a serial byte stream. During boot it takes one byte per valid cycle and packs each group of six bytes into a 48-bit instruction word, first byte in the top byte. It stores the words in an internal instruction memory at rising word addresses starting from zero.

The first complete word does two jobs. It is stored like any other word, and it is also kept as a launch descriptor. When the byte that carries the end-of-stream flag arrives, the loader decodes the descriptor into a word count and a base address. It then fetches that many words in order from the base and presents each one on a valid/ready output, where the dispatch logic picks it up. After the last accepted word it gives a one-cycle done pulse. It then stays halted until the next reset.

The controller is a six-state machine. ST_LOAD packs and writes bytes. It leaves for ST_DECODE on the flagged byte. ST_DECODE goes to ST_FINISH when the count is zero and to ST_FETCH otherwise. ST_FETCH starts the one-cycle memory read and always moves to ST_ISSUE. ST_ISSUE holds the word valid. On a handshake it returns to ST_FETCH, or it goes to ST_FINISH if that was the final word. ST_FINISH raises done for one cycle and moves to ST_HALT. ST_HALT holds until reset.

Top module: `boot_loader`

## Requirements
- R1: Six accepted bytes form one word. The earliest byte lands in bits [47:40] and the sixth byte lands in bits [7:0].
- R2: Full word k, built from stream bytes 6k to 6k+5, is stored at memory address k modulo the memory depth (256 words by default).
- R3: The first full word of a stream is the descriptor. Its bits [5:0] are the issue count (0 to 63) and its bits [23:6] are the base address. Bits [47:24] have no effect. A stream with no full word acts as a descriptor of zero.
- R4: The issued words are the memory contents at base, base+1, ... base+count-1, in that order. Only the low address bits matching the memory depth are used, so the sequence wraps past the top address to 0.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_word stays unchanged. The fetch address moves on only after a handshake.
- R6: A count of zero issues no word and still gives the done pulse.
- R7: done is high for exactly one cycle, the cycle after the final handshake (or after decode for a zero count). It occurs once per boot.
- R8: Trailing bytes that do not fill a whole word are not written to memory. Memory contents survive reset; only the controller is cleared.
- R9: Bytes offered after the flagged byte (during fetch or after done) are ignored. No further word is issued and no further done is raised.
- R10: After reset, out_valid and done are low and the loader waits for bytes.
- R11: At most 63 words are issued per boot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| in_valid | input | 1 | A boot byte is present this cycle |
| in_byte | input | 8 | Boot byte |
| in_last | input | 1 | Marks the final byte of the stream (qualified by in_valid) |
| out_valid | output | 1 | An instruction word is offered |
| out_word | output | 48 | Instruction word being offered |
| out_ready | input | 1 | Dispatch accepts the offered word |
| done | output | 1 | One-cycle pulse when the issue pass is complete |

## Verification
The checker assumes that the dispatch side can stall the output at will, and that each reset starts a fresh boot. It does not assume any input pacing. The bench feeds bytes with random gaps and drives out_ready from a random draw that it redraws every cycle. This exercises the stall rule in R5 under many stall lengths. Descriptors are chosen so that every fetched address holds a word the bench itself wrote, whether in the current boot or in an earlier one. The wrap at the top address, a zero count, a stream with no full word, a partial tail over older contents and the full 63-word count are driven as directed cases.

// File: rtl/boot_pkg.sv
package boot_pkg;

    // Controller states of the boot loader
    typedef enum logic [2:0] {
        ST_LOAD,
        ST_DECODE,
        ST_FETCH,
        ST_ISSUE,
        ST_FINISH,
        ST_HALT
    } boot_state_t;

    // Default geometry shared by the loader and its checker
    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_BYTES_PW  = 6;
    localparam int DEF_SIZE_W    = 6;
    localparam int DEF_BASE_W    = 18;
    localparam int DEF_MEM_AW    = 8;

endpackage

// File: rtl/boot_packer.sv
module boot_packer #(
    parameter  int BYTE_W   = 8,
    parameter  int BYTES_PW = 6,
    parameter  int AW       = 8,
    localparam int WORD_W   = BYTE_W * BYTES_PW,
    localparam int CNT_W    = $clog2(BYTES_PW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_word,
    output logic              first_word,
    output logic              end_stream
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BYTES_PW - 1);

    logic [WORD_W-BYTE_W-1:0] acc_q;
    logic [CNT_W-1:0]         slot_q;
    logic [AW-1:0]            addr_q;
    logic                     had_word_q;
    logic                     take;
    logic                     slot_full;

    assign take       = en && in_valid;
    assign slot_full  = (slot_q == LAST_SLOT);
    assign wr_word    = {acc_q, in_byte};
    assign wr_en      = take && slot_full;
    assign wr_addr    = addr_q;
    assign first_word = wr_en && !had_word_q;
    assign end_stream = take && in_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            addr_q     <= '0;
            had_word_q <= 1'b0;
        end else if (take) begin
            if (slot_full) begin
                slot_q     <= '0;
                addr_q     <= addr_q + 1'b1;
                had_word_q <= 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Assembly register: shifts in bytes, oldest ends up most significant
    always_ff @(posedge clk) begin
        if (take) begin
            acc_q <= {acc_q[WORD_W-2*BYTE_W-1:0], in_byte};
        end
    end

endmodule

// File: rtl/boot_ram.sv
module boot_ram #(
    parameter  int AW    = 8,
    parameter  int W     = 48,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Registered read; holds its value between read strobes
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_pkg::*;
#(
    parameter  int MEM_AW   = DEF_MEM_AW,
    parameter  int BYTE_W   = DEF_BYTE_W,
    parameter  int BYTES_PW = DEF_BYTES_PW,
    parameter  int SIZE_W   = DEF_SIZE_W,
    localparam int WORD_W   = BYTE_W * BYTES_PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    input  logic              out_ready,
    output logic              done
);

    boot_state_t state_q, state_d;

    logic              pk_en;
    logic              pk_we;
    logic [MEM_AW-1:0] pk_addr;
    logic [WORD_W-1:0] pk_word;
    logic              pk_first;
    logic              pk_end;

    logic [SIZE_W-1:0] cnt_q;
    logic [MEM_AW-1:0] base_q;
    logic [SIZE_W-1:0] idx_q;
    logic              rd_en;
    logic [MEM_AW-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              last_word;
    logic              accept;

    boot_packer #(
        .BYTE_W   (BYTE_W),
        .BYTES_PW (BYTES_PW),
        .AW       (MEM_AW)
    ) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (pk_en),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_last    (in_last),
        .wr_en      (pk_we),
        .wr_addr    (pk_addr),
        .wr_word    (pk_word),
        .first_word (pk_first),
        .end_stream (pk_end)
    );

    boot_ram #(
        .AW (MEM_AW),
        .W  (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (pk_we),
        .waddr (pk_addr),
        .wdata (pk_word),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    assign rd_addr   = base_q + MEM_AW'(idx_q);
    assign last_word = (idx_q == cnt_q - 1'b1);
    assign accept    = (state_q == ST_ISSUE) && out_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   if (pk_end) state_d = ST_DECODE;
            ST_DECODE: state_d = (cnt_q == '0) ? ST_FINISH : ST_FETCH;
            ST_FETCH:  state_d = ST_ISSUE;
            ST_ISSUE:  if (out_ready) state_d = last_word ? ST_FINISH : ST_FETCH;
            ST_FINISH: state_d = ST_HALT;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_HALT;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        pk_en     = 1'b0;
        rd_en     = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_LOAD:   pk_en     = 1'b1;
            ST_DECODE: ;
            ST_FETCH:  rd_en     = 1'b1;
            ST_ISSUE:  out_valid = 1'b1;
            ST_FINISH: done      = 1'b1;
            ST_HALT:   ;
            default:   ;
        endcase
    end

    assign out_word = rd_word;

    // Descriptor capture: count field and the base bits the memory decodes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            base_q <= '0;
        end else if (pk_first) begin
            cnt_q  <= pk_word[SIZE_W-1:0];
            base_q <= pk_word[SIZE_W +: MEM_AW];
        end
    end

    // Issue index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == ST_DECODE) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int WORD_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              out_ready,
    input logic              done
);

    logic       seen_done_q;
    logic [6:0] hs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_done_q <= 1'b0;
            hs_q        <= '0;
        end else begin
            if (done) seen_done_q <= 1'b1;
            if (out_valid && out_ready && hs_q != 7'h7f) hs_q <= hs_q + 1'b1;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid)); // R7

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_done_q |-> (!out_valid && !done)); // R9

    AST_ISSUE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q <= 7'd63); // R11

endmodule

bind boot_loader boot_loader_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ready (out_ready),
    .done      (done)
);

// File: tb/boot_loader_test.sv
module boot_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [47:0] out_word;
    logic        out_ready = 1'b0;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  stim  [0:1599];
    logic [47:0] model [0:255];
    logic [47:0] expq  [0:63];
    int          exp_n;
    int          ready_pct;
    int          gap_pct;

    always #5 clk = ~clk;

    boot_loader uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_ready (out_ready),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic put_word(input int k, input logic [47:0] w);
        for (int j = 0; j < 6; j++) stim[6*k+j] = w[47-8*j -: 8];
    endtask

    function automatic logic [47:0] word_of(input int k);
        logic [47:0] w = '0;
        for (int j = 0; j < 6; j++) w = {w[39:0], stim[6*k+j]};
        return w;
    endfunction

    function automatic logic [47:0] rnd48();
        return {$urandom(), $urandom()} & 48'hffff_ffff_ffff;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", 48'(out_valid), 48'd0);
        chk(done == 1'b0, "R10 done after reset", 48'(done), 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Expected issue list from the requirement rules (R1 R2 R3 R4 R8)
    task automatic build_expect(input int nbytes);
        int nfull = nbytes / 6;
        logic [47:0] d = '0;
        int cnt, base;
        for (int k = 0; k < nfull; k++) model[k % 256] = word_of(k);
        if (nfull > 0) d = word_of(0);
        cnt  = int'(d[5:0]);
        base = int'(d[23:6]);
        exp_n = cnt;
        for (int i = 0; i < cnt; i++) expq[i] = model[(base + i) % 256];
    endtask

    task automatic run_boot(input int nbytes, input string tag);
        int got = 0;
        int dcnt = 0;
        build_expect(nbytes);
        fork
            begin
                for (int i = 0; i < nbytes; i++) begin
                    while (($urandom() % 100) < gap_pct) begin
                        in_valid = 1'b0;
                        @(negedge clk);
                    end
                    in_valid = 1'b1;
                    in_byte  = stim[i];
                    in_last  = (i == nbytes - 1);
                    @(negedge clk);
                end
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            begin
                int cyc = 0;
                while (dcnt == 0 && cyc < 20000) begin
                    @(negedge clk);
                    cyc++;
                    out_ready = (($urandom() % 100) < ready_pct);
                    if (done) dcnt++;
                    if (out_valid && out_ready) begin
                        if (got < exp_n)
                            chk(out_word == expq[got], {"R1 R2 R3 R4 word ", tag}, out_word, expq[got]);
                        got++;
                    end
                end
            end
        join
        chk(got == exp_n, {"R4 R6 R11 issued count ", tag}, 48'(got), 48'(exp_n));
        chk(dcnt == 1, {"R7 done pulse ", tag}, 48'(dcnt), 48'd1);
    endtask

    // R9: more bytes after the stream ended must change nothing at the outputs
    task automatic quiet_check();
        int bad = 0;
        out_ready = 1'b1;
        for (int i = 0; i < 12; i++) begin
            in_valid = 1'b1;
            in_byte  = 8'($urandom());
            in_last  = (i == 11);
            @(negedge clk);
            if (out_valid || done) bad++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (out_valid || done) bad++;
        end
        chk(bad == 0, "R9 bytes after end ignored", 48'(bad), 48'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0b01));
        for (int k = 0; k < 256; k++) model[k] = '0;

        // Full memory fill; count 5 from base low bits 254 wraps to 0..2 (R4), high bits set (R3)
        for (int k = 0; k < 256; k++) put_word(k, rnd48());
        put_word(0, {24'hA5C3F1, 18'((7 << 8) | 254), 6'd5});
        gap_pct = 20; ready_pct = 70;
        do_reset();
        run_boot(256 * 6, "wrap");
        quiet_check();

        // Directed small boot with ready always high
        for (int k = 0; k < 4; k++) put_word(k, rnd48());
        put_word(0, {24'hFFFFFF, 18'd1, 6'd3});
        gap_pct = 0; ready_pct = 100;
        do_reset();
        run_boot(24, "small");

        // Zero count (R6)
        for (int k = 0; k < 3; k++) put_word(k, rnd48());
        put_word(0, {24'h123456, 18'd2, 6'd0});
        do_reset();
        run_boot(18, "zero");
        quiet_check();

        // No full word at all: descriptor reads as zero (R3 R6)
        do_reset();
        run_boot(4, "nofull");

        // Partial tail over older contents, kept across reset (R8)
        for (int k = 0; k < 3; k++) put_word(k, rnd48());
        put_word(0, {24'h0, 18'd2, 6'd3});
        gap_pct = 30; ready_pct = 50;
        do_reset();
        run_boot(16, "partial");

        // Largest count (R11)
        for (int k = 0; k < 70; k++) put_word(k, rnd48());
        put_word(0, {24'h0F0F0F, 18'd0, 6'd63});
        ready_pct = 60;
        do_reset();
        run_boot(70 * 6, "max");

        // Constrained random boots
        for (int r = 0; r < 10; r++) begin
            int nw = 1 + int'($urandom() % 40);
            int extra = int'($urandom() % 6);
            for (int k = 0; k < nw + 1; k++) put_word(k, rnd48());
            put_word(0, {24'($urandom()), 18'($urandom()), 6'($urandom())});
            gap_pct = int'($urandom() % 50);
            ready_pct = 30 + int'($urandom() % 71);
            do_reset();
            run_boot(nw * 6 + extra, "random");
            if (r % 3 == 0) quiet_check();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule